// File: doc/BRIEF.md
# Video Port Bus Unlock Gate

This block sits on an asynchronous-style processor bus in front of the address window that holds the video controller's ports. When the board's revision strap says that lock hardware is fitted, the gate comes out of reset closed. While it is closed, a cycle aimed at the video window is not forwarded and is never acknowledged, so the bus master stalls. Software first reads a small version register to learn whether the lock is present. It then opens the gate by writing a 32-bit signature into a two-word key register. The gate stays open until the next reset.

The key can arrive as one long transfer, which the bus splits into two word cycles, or as two separate word writes. Either way the upper half goes to the lower key word address and the lower half goes to the next word. A bad half, or a write that does not drive both byte lanes, discards any half already matched. The gate answers its own registers itself. Cycles to any other address keep the acknowledge of the rest of the system, whether the gate is open or closed.

Top module: `vport_lock_gate`

## Requirements
- R1: After reset with a nonzero revision strap the gate is closed: no bus cycle to byte addresses $C00000..$C0001F raises `vport_sel_o` or `bus_ack_o`.
- R2: After reset with a revision strap of zero the gate is open from the first cycle.
- R3: While closed, a read or write in the video window leaves `vport_sel_o` low and `bus_ack_o` low for as long as the strobe is held.
- R4: While open, a cycle in the video window raises `vport_sel_o`, and `bus_ack_o` follows `vport_ack_i`.
- R5: A read of the version word at byte $A10000 is acknowledged by the gate one clock after the strobe rises. It returns the revision strap in data bits 3:0 and zeros in bits 15:4.
- R6: The gate opens after a full-word write equal to KEY[31:16] at byte $A14000, followed by a full-word write equal to KEY[15:0] at byte $A14002. KEY defaults to 32'h53454741.
- R7: A key-word write with the wrong value, or with only one byte strobe, leaves the gate closed and discards a matched upper half.
- R8: A lower-half write that has no matched upper half before it does not open the gate, in either write order.
- R9: A cycle outside the video window and outside the gate's own words has `bus_ack_o` equal to `sys_ack_i`, open or closed.
- R10: Reads and writes of the key words are acknowledged by the gate, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rev_strap_i | input | 4 | Board revision strap; nonzero means lock fitted |
| bus_as_i | input | 1 | Address strobe, high for the whole cycle |
| bus_rd_i | input | 1 | 1 = read, 0 = write |
| bus_uds_i | input | 1 | Upper byte strobe (data 15:8) |
| bus_lds_i | input | 1 | Lower byte strobe (data 7:0) |
| bus_addr_i | input | 23 | Word address, byte address bits 23:1 |
| bus_wdata_i | input | 16 | Write data |
| vport_ack_i | input | 1 | Acknowledge from the video controller |
| sys_ack_i | input | 1 | Acknowledge from the rest of the system |
| vport_sel_o | output | 1 | Forwarded select to the video ports |
| bus_ack_o | output | 1 | Transfer acknowledge to the bus master |
| bus_rdata_o | output | 16 | Read data of the gate's own words |

## Verification
The hardest case to reach is a lower key half that arrives with a stale or missing upper half. This covers the lower word written before the upper one, a correct lower word after a wrong one, and an upper half sent on one byte lane. Each of these has to leave the window closed, so the stimulus builds each ordering from separate word cycles. It then probes the video window, where a missing acknowledge is the only visible result. The strobe is released after a fixed wait, because a closed gate would otherwise stall the cycle forever.

// File: rtl/vlg_pkg.sv
package vlg_pkg;

  typedef struct packed {
    logic vport;   // video port window
    logic ver;     // version word
    logic key_hi;  // upper key word
    logic key_lo;  // lower key word
  } region_t;

  // word address equals a byte address
  function automatic logic word_at(input logic [23:1] a, input logic [23:0] byte_addr);
    return a == byte_addr[23:1];
  endfunction

  // word address lies inside an aligned block of 2**lg2 bytes
  function automatic logic in_block(input logic [23:1] a, input logic [23:0] base,
                                    input int unsigned lg2);
    return ((a ^ base[23:1]) >> (lg2 - 1)) == '0;
  endfunction

  // one half of the signature
  function automatic logic half_ok(input logic [15:0] d, input logic [31:0] key,
                                   input logic upper, input logic full);
    return full && (d == (upper ? key[31:16] : key[15:0]));
  endfunction

endpackage

// File: rtl/vlg_decode.sv
module vlg_decode
  import vlg_pkg::*;
#(
  parameter logic [23:0] VPORT_BASE = 24'hC00000,
  parameter int unsigned VPORT_LG2  = 5,
  parameter logic [23:0] VER_ADDR   = 24'hA10000,
  parameter logic [23:0] KEY_ADDR   = 24'hA14000
) (
  input  logic [23:1] addr_i,
  output region_t     rgn_o
);
  localparam logic [23:0] KEY_LO_ADDR = KEY_ADDR + 24'd2;

  always_comb begin
    rgn_o.vport  = in_block(addr_i, VPORT_BASE, VPORT_LG2);
    rgn_o.ver    = word_at(addr_i, VER_ADDR);
    rgn_o.key_hi = word_at(addr_i, KEY_ADDR);
    rgn_o.key_lo = word_at(addr_i, KEY_LO_ADDR);
  end
endmodule

// File: rtl/vlg_key_lock.sv
module vlg_key_lock
  import vlg_pkg::*;
#(
  parameter logic [31:0] KEY   = 32'h53454741,
  parameter int unsigned REV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REV_W-1:0] rev_strap_i,
  input  logic             hi_wr_i,
  input  logic             lo_wr_i,
  input  logic             full_i,
  input  logic [15:0]      wdata_i,
  output logic             unlocked_o,
  output logic             hi_ok_o,
  output logic             unlock_evt_o
);
  logic unlocked_q, hi_ok_q;

  assign unlock_evt_o = lo_wr_i && hi_ok_q && half_ok(wdata_i, KEY, 1'b0, full_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked_q <= (rev_strap_i == '0);
      hi_ok_q    <= 1'b0;
    end else begin
      if (hi_wr_i) hi_ok_q <= half_ok(wdata_i, KEY, 1'b1, full_i);
      if (lo_wr_i) hi_ok_q <= 1'b0;
      if (unlock_evt_o) unlocked_q <= 1'b1;
    end
  end

  assign unlocked_o = unlocked_q;
  assign hi_ok_o    = hi_ok_q;
endmodule

// File: rtl/vlg_bus_resp.sv
module vlg_bus_resp
  import vlg_pkg::*;
#(
  parameter int unsigned REV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_i,
  input  logic             rd_i,
  input  region_t          rgn_i,
  input  logic             unlocked_i,
  input  logic             vport_ack_i,
  input  logic             sys_ack_i,
  input  logic [REV_W-1:0] rev_strap_i,
  output logic             cyc_start_o,
  output logic             own_hit_o,
  output logic             vport_sel_o,
  output logic             bus_ack_o,
  output logic [15:0]      bus_rdata_o
);
  logic        as_q, own_ack_q;
  logic [15:0] rdata_q;

  assign cyc_start_o = as_i && !as_q;
  assign own_hit_o   = rgn_i.ver || rgn_i.key_hi || rgn_i.key_lo;
  assign vport_sel_o = as_i && rgn_i.vport && unlocked_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      as_q      <= 1'b0;
      own_ack_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      as_q <= as_i;
      if (!as_i) begin
        own_ack_q <= 1'b0;
        rdata_q   <= '0;
      end else if (cyc_start_o && own_hit_o) begin
        own_ack_q <= 1'b1;
        rdata_q   <= (rd_i && rgn_i.ver) ? 16'(rev_strap_i) : 16'h0000;
      end
    end
  end

  assign bus_ack_o = own_ack_q
                   || (vport_sel_o && vport_ack_i)
                   || (as_i && !rgn_i.vport && !own_hit_o && sys_ack_i);
  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/vport_lock_gate.sv
module vport_lock_gate
  import vlg_pkg::*;
#(
  parameter logic [31:0] KEY        = 32'h53454741,
  parameter int unsigned REV_W      = 4,
  parameter logic [23:0] VPORT_BASE = 24'hC00000,
  parameter int unsigned VPORT_LG2  = 5,
  parameter logic [23:0] VER_ADDR   = 24'hA10000,
  parameter logic [23:0] KEY_ADDR   = 24'hA14000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REV_W-1:0] rev_strap_i,
  input  logic             bus_as_i,
  input  logic             bus_rd_i,
  input  logic             bus_uds_i,
  input  logic             bus_lds_i,
  input  logic [23:1]      bus_addr_i,
  input  logic [15:0]      bus_wdata_i,
  input  logic             vport_ack_i,
  input  logic             sys_ack_i,
  output logic             vport_sel_o,
  output logic             bus_ack_o,
  output logic [15:0]      bus_rdata_o
);
  region_t rgn;
  logic    cyc_start_w, own_hit_w, unlocked_w, hi_ok_w, unlock_evt_w;
  logic    hi_wr_w, lo_wr_w, full_w;

  vlg_decode #(
    .VPORT_BASE(VPORT_BASE), .VPORT_LG2(VPORT_LG2),
    .VER_ADDR(VER_ADDR), .KEY_ADDR(KEY_ADDR)
  ) u_dec (
    .addr_i(bus_addr_i), .rgn_o(rgn)
  );

  assign full_w  = bus_uds_i && bus_lds_i;
  assign hi_wr_w = cyc_start_w && !bus_rd_i && rgn.key_hi;
  assign lo_wr_w = cyc_start_w && !bus_rd_i && rgn.key_lo;

  vlg_key_lock #(.KEY(KEY), .REV_W(REV_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .rev_strap_i(rev_strap_i),
    .hi_wr_i(hi_wr_w), .lo_wr_i(lo_wr_w), .full_i(full_w),
    .wdata_i(bus_wdata_i), .unlocked_o(unlocked_w),
    .hi_ok_o(hi_ok_w), .unlock_evt_o(unlock_evt_w)
  );

  vlg_bus_resp #(.REV_W(REV_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .as_i(bus_as_i), .rd_i(bus_rd_i),
    .rgn_i(rgn), .unlocked_i(unlocked_w), .vport_ack_i(vport_ack_i),
    .sys_ack_i(sys_ack_i), .rev_strap_i(rev_strap_i),
    .cyc_start_o(cyc_start_w), .own_hit_o(own_hit_w),
    .vport_sel_o(vport_sel_o), .bus_ack_o(bus_ack_o),
    .bus_rdata_o(bus_rdata_o)
  );
endmodule

// File: rtl/vlg_checker.sv
module vlg_checker #(
  parameter logic [31:0] KEY = 32'h53454741
) (
  input logic        clk,
  input logic        rst_n,
  input logic        as_i,
  input logic        in_vport_i,
  input logic        own_hit_i,
  input logic        unlocked_i,
  input logic        hi_ok_i,
  input logic        hi_wr_i,
  input logic        lo_wr_i,
  input logic        full_i,
  input logic [15:0] wdata_i,
  input logic        vport_ack_i,
  input logic        sys_ack_i,
  input logic        vport_sel_i,
  input logic        bus_ack_i
);
  AST_CLOSED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    as_i && in_vport_i && !unlocked_i |-> !bus_ack_i && !vport_sel_i); // R3

  AST_OPEN_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    as_i && in_vport_i && unlocked_i |-> vport_sel_i && (bus_ack_i == vport_ack_i)); // R4

  AST_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_i |=> unlocked_i); // R6

  AST_OPEN_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_i ##1 unlocked_i |-> $past(hi_ok_i) && $past(lo_wr_i)); // R8

  AST_BAD_HALF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_i && !(full_i && wdata_i == KEY[31:16]) |=> !hi_ok_i); // R7

  AST_LO_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_i |=> !hi_ok_i); // R7

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    as_i && !in_vport_i && !own_hit_i |-> bus_ack_i == sys_ack_i); // R9
endmodule

bind vport_lock_gate vlg_checker #(.KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_i(bus_as_i), .in_vport_i(rgn.vport),
  .own_hit_i(own_hit_w), .unlocked_i(unlocked_w), .hi_ok_i(hi_ok_w),
  .hi_wr_i(hi_wr_w), .lo_wr_i(lo_wr_w), .full_i(full_w),
  .wdata_i(bus_wdata_i), .vport_ack_i(vport_ack_i), .sys_ack_i(sys_ack_i),
  .vport_sel_i(vport_sel_o), .bus_ack_i(bus_ack_o)
);

// File: tb/vport_lock_gate_bench.sv
module vport_lock_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rev = 4'h1;
  logic        as_r = 1'b0, rd_r = 1'b1, uds_r = 1'b0, lds_r = 1'b0;
  logic [23:1] addr_r = '0;
  logic [15:0] wd_r = '0;
  logic        vack = 1'b1, sack = 1'b1;
  logic        sel, ack;
  logic [15:0] rdata;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  vport_lock_gate u_vport_lock_gate (
    .clk(clk), .rst_n(rst_n), .rev_strap_i(rev), .bus_as_i(as_r),
    .bus_rd_i(rd_r), .bus_uds_i(uds_r), .bus_lds_i(lds_r),
    .bus_addr_i(addr_r), .bus_wdata_i(wd_r), .vport_ack_i(vack),
    .sys_ack_i(sack), .vport_sel_o(sel), .bus_ack_o(ack), .bus_rdata_o(rdata)
  );

  typedef struct packed {
    logic        rd;
    logic [23:0] a;
    logic [15:0] d;
    logic        ack;
    logic [15:0] rdat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 24'hA10000, 16'h0000, 1'b1, 16'h0001, 4'd5},
    '{1'b1, 24'hC00000, 16'h0000, 1'b0, 16'h0000, 4'd1},
    '{1'b0, 24'hC00004, 16'h8144, 1'b0, 16'h0000, 4'd3},
    '{1'b1, 24'h000100, 16'h0000, 1'b1, 16'h0000, 4'd9},
    '{1'b0, 24'hA14000, 16'h5345, 1'b1, 16'h0000, 4'd10},
    '{1'b0, 24'hA14002, 16'h0000, 1'b1, 16'h0000, 4'd7},
    '{1'b0, 24'hA14002, 16'h4741, 1'b1, 16'h0000, 4'd7},
    '{1'b1, 24'hC00008, 16'h0000, 1'b0, 16'h0000, 4'd7},
    '{1'b0, 24'hA14000, 16'h5345, 1'b1, 16'h0000, 4'd6},
    '{1'b0, 24'hA14002, 16'h4741, 1'b1, 16'h0000, 4'd6},
    '{1'b1, 24'hC00008, 16'h0000, 1'b1, 16'h0000, 4'd6},
    '{1'b0, 24'hC0001E, 16'h1234, 1'b1, 16'h0000, 4'd4},
    '{1'b1, 24'hC00020, 16'h0000, 1'b1, 16'h0000, 4'd9}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle: strobe held two clocks, sampled on the falling edge
  task automatic cyc(input logic rd, input logic [23:0] a, input logic [15:0] d,
                     input logic [1:0] be, output logic k, output logic s,
                     output logic [15:0] q);
    @(negedge clk);
    as_r = 1'b1; rd_r = rd; addr_r = a[23:1]; wd_r = d;
    uds_r = be[1]; lds_r = be[0];
    @(negedge clk);
    @(negedge clk);
    k = ack; s = sel; q = rdata;
    as_r = 1'b0; rd_r = 1'b1; uds_r = 1'b0; lds_r = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [3:0] strap);
    @(negedge clk);
    rst_n = 1'b0; rev = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    logic k, s;
    logic [15:0] q;

    // R1 reset state, gate closed
    do_reset(4'h1);
    chk("R1 sel idle", {15'd0, sel}, 16'd0);
    chk("R1 ack idle", {15'd0, ack}, 16'd0);
    chk("R1 rdata idle", rdata, 16'd0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].rd, VEC[i].a, VEC[i].d, 2'b11, k, s, q);
      chk($sformatf("R%0d vec%0d ack", VEC[i].req, i), {15'd0, k}, {15'd0, VEC[i].ack});
      chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), q, VEC[i].rdat);
    end

    // R4 open: ack follows the controller, select still raised
    vack = 1'b0;
    cyc(1'b1, 24'hC00000, 16'h0, 2'b11, k, s, q);
    chk("R4 no vport ack", {15'd0, k}, 16'd0);
    chk("R4 sel open", {15'd0, s}, 16'd1);
    vack = 1'b1;

    // R9 outside range follows sys ack
    sack = 1'b0;
    cyc(1'b1, 24'h200000, 16'h0, 2'b11, k, s, q);
    chk("R9 sys ack low", {15'd0, k}, 16'd0);
    sack = 1'b1;

    // R8 low half before high half
    do_reset(4'h1);
    cyc(1'b0, 24'hA14002, 16'h4741, 2'b11, k, s, q);
    cyc(1'b0, 24'hA14000, 16'h5345, 2'b11, k, s, q);
    cyc(1'b1, 24'hC00000, 16'h0, 2'b11, k, s, q);
    chk("R8 reversed order stays closed", {15'd0, k}, 16'd0);
    chk("R3 sel closed", {15'd0, s}, 16'd0);
    cyc(1'b0, 24'hA14002, 16'h4741, 2'b11, k, s, q);
    cyc(1'b1, 24'hC00000, 16'h0, 2'b11, k, s, q);
    chk("R6 completes after pair", {15'd0, k}, 16'd1);

    // R7 upper half on a single byte lane
    do_reset(4'h3);
    cyc(1'b0, 24'hA14000, 16'h5345, 2'b10, k, s, q);
    cyc(1'b0, 24'hA14002, 16'h4741, 2'b11, k, s, q);
    cyc(1'b1, 24'hC00010, 16'h0, 2'b11, k, s, q);
    chk("R7 byte write rejected", {15'd0, k}, 16'd0);
    // R9 while closed
    sack = 1'b0;
    cyc(1'b0, 24'hFF0000, 16'h0, 2'b11, k, s, q);
    chk("R9 closed sys ack low", {15'd0, k}, 16'd0);
    sack = 1'b1;
    // R10 key read returns zero, acked
    cyc(1'b1, 24'hA14000, 16'h0, 2'b11, k, s, q);
    chk("R10 key read ack", {15'd0, k}, 16'd1);
    chk("R10 key read data", q, 16'd0);
    // R5 version shows strap
    cyc(1'b1, 24'hA10000, 16'h0, 2'b11, k, s, q);
    chk("R5 version strap 3", q, 16'h0003);

    // R2 strap zero: open at once
    do_reset(4'h0);
    cyc(1'b1, 24'hC00004, 16'h0, 2'b11, k, s, q);
    chk("R2 open without key", {15'd0, k}, 16'd1);
    cyc(1'b1, 24'hA10000, 16'h0, 2'b11, k, s, q);
    chk("R5 version strap 0", q, 16'h0000);

    finish_up();
  end
endmodule